// File: doc/BRIEF.md
# Three-Semaphore Privilege Relay

This controller sits beside one processor of a two-processor system that shares buffer memory. Two copies of it, one per side, pass a single exclusive privilege back and forth. The buffer contents and the data transfer are outside the block. The privilege is carried entirely by a two-port bank of three hardware semaphores, named A, B and C. A side is privileged whenever it owns two of them. There is no shared state word and nothing depends on timing, so the two processors may run at any relative speed.

When local logic asks to hand over, the controller frees the older of its two semaphores. It then requests the next semaphore in the fixed rotation. A refused request is polled again until the bank grants it, and the local side is free to do other work meanwhile. Every state has exactly one successor, so each side walks a fixed free/get/free/get pattern through A, B and C. The side built with `START_PRIV` set takes A and B together at power-up and starts after a time-out. The other side waits for the same time-out and then claims C.

One full round is six handovers, three in each direction. After it, both sides are back in their power-up ownership.

Top module: `privilege_relay`

## Requirements
- R1: Semaphore masks are one-hot per semaphore: bit 0 is A, bit 1 is B, bit 2 is C. The bank answers a get on `sem_grant` in the cycle after the request, with the granted bits set. A side built with `START_PRIV`=1 drives `sem_get`=3'b011 from reset. A side built with `START_PRIV`=0 first requests C (3'b100) and then A (3'b001).
- R2: The starting side raises `has_priv` exactly `TMO_CYCLES`+1 cycles after the cycle in which A and B are both granted. The other side issues its first get exactly `TMO_CYCLES` cycles after reset is released.
- R3: `has_priv` is low during reset. Two connected controllers never hold `has_priv` at the same time. A get and a free are never driven in the same cycle.
- R4: `pass_req` sampled while `has_priv` is high produces, in the next cycle, a one-hot free of the older owned semaphore. `has_priv` is low in that same cycle.
- R5: `pass_req` has no effect while `has_priv` is low: no free is issued and `has_priv` stays low.
- R6: The cycle after a free, the controller requests the one semaphore it does not own. For a freed mask f this is {f[0], f[2:1]}. Frees and gets strictly alternate.
- R7: A refused get is repeated in alternating request and response cycles until it is granted. `has_priv` stays low while polling.
- R8: Each side frees A, B, C in that cyclic order. The global free order across six handovers is A, C, B, A, C, B, alternating sides and starting with the initially privileged side. After those six, the starting side again owns exactly A and B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pass_req | input | 1 | Request from local logic to hand the privilege to the peer |
| has_priv | output | 1 | Local side currently holds the privilege |
| sem_get | output | 3 | One-hot semaphore acquire request (A, B, C on bits 0..2) |
| sem_free | output | 3 | One-hot semaphore release |
| sem_grant | input | 3 | Bank answer to the previous cycle's get, one bit per granted semaphore |

## Verification
The bench builds two controllers, one with `START_PRIV`=1 and one with `START_PRIV`=0, both with `TMO_CYCLES`=5. They share a behavioural semaphore bank. The short time-out puts the exact start-up offsets of both sides within a few cycles of reset. The privileged side holds its privilege for long stretches, which keeps the other side polling many times in a row. Twelve handovers cover two complete rotations, so wrap-around of the oldest-semaphore pointer on both sides is exercised.

// File: rtl/privilege_relay.sv
module privilege_relay #(
  parameter bit          START_PRIV = 1'b1,
  parameter int unsigned TMO_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pass_req,
  output logic       has_priv,
  output logic [2:0] sem_get,
  output logic [2:0] sem_free,
  input  logic [2:0] sem_grant
);

  localparam int unsigned TW = (TMO_CYCLES > 1) ? $clog2(TMO_CYCLES) : 1;
  localparam logic [TW-1:0] TLAST = TW'(TMO_CYCLES - 1);

  typedef enum logic [2:0] {S_WAIT, S_REQ, S_RSP, S_HOLD, S_REL} st_t;

  st_t           st;
  logic [2:0]    want;
  logic [1:0]    old;
  logic          booted;
  logic          half;
  logic [TW-1:0] tmr;

  function automatic logic [1:0] nxt(input logic [1:0] i);
    return (i == 2'd2) ? 2'd0 : i + 2'd1;
  endfunction

  function automatic logic [2:0] bit_of(input logic [1:0] i);
    return 3'b001 << i;
  endfunction

  wire [2:0] left = want & ~sem_grant;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr    <= '0;
      booted <= 1'b0;
      half   <= !START_PRIV;
      if (START_PRIV) begin
        st   <= S_REQ;
        want <= 3'b011;
        old  <= 2'd0;
      end else begin
        st   <= S_WAIT;
        want <= 3'b100;
        old  <= 2'd1;
      end
    end else begin
      case (st)
        S_WAIT:
          if (tmr == TLAST) begin
            tmr    <= '0;
            st     <= booted ? S_HOLD : S_REQ;
            booted <= 1'b1;
          end else begin
            tmr <= tmr + 1'b1;
          end
        S_REQ: st <= S_RSP;
        S_RSP:
          if (left != 3'b000) begin
            want <= left;
            st   <= S_REQ;
          end else if (!booted) begin
            booted <= 1'b1;
            st     <= S_WAIT;
          end else if (half) begin
            half <= 1'b0;
            want <= bit_of(nxt(nxt(old)));
            st   <= S_REQ;
          end else begin
            old <= nxt(old);
            st  <= S_HOLD;
          end
        S_HOLD: if (pass_req) st <= S_REL;
        S_REL: begin
          want <= bit_of(nxt(nxt(old)));
          st   <= S_REQ;
        end
        default: st <= S_WAIT;
      endcase
    end
  end

  assign has_priv = (st == S_HOLD);
  assign sem_get  = (st == S_REQ) ? want : 3'b000;
  assign sem_free = (st == S_REL) ? bit_of(old) : 3'b000;

endmodule

// File: rtl/privilege_relay_chk.sv
module privilege_relay_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pass_req,
  input logic       has_priv,
  input logic [2:0] sem_get,
  input logic [2:0] sem_free
);

  logic [2:0] last_free;
  logic       seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_free <= 3'b000;
      seen      <= 1'b0;
    end else if (sem_free != 3'b000) begin
      last_free <= sem_free;
      seen      <= 1'b1;
    end
  end

  a_r3_no_get_with_free: assert property (@(posedge clk) disable iff (!rst_n)
    !((sem_get != 3'b000) && (sem_free != 3'b000)));

  a_r4_free_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sem_free));

  a_r4_priv_drop_with_free: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(has_priv) |-> (sem_free != 3'b000));

  a_r4_free_after_priv: assert property (@(posedge clk) disable iff (!rst_n)
    (sem_free != 3'b000) |-> $past(has_priv));

  a_r5_pass_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_req && !has_priv) |=> (sem_free == 3'b000));

  a_r6_get_follows_free: assert property (@(posedge clk) disable iff (!rst_n)
    (sem_free != 3'b000) |=> (sem_get == {$past(sem_free[0]), $past(sem_free[2:1])}));

  a_r7_poll_alternates: assert property (@(posedge clk) disable iff (!rst_n)
    (sem_get != 3'b000) |=> (sem_get == 3'b000));

  a_r8_free_rotation: assert property (@(posedge clk) disable iff (!rst_n)
    ((sem_free != 3'b000) && seen) |-> (sem_free == {last_free[1:0], last_free[2]}));

endmodule

bind privilege_relay privilege_relay_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pass_req(pass_req), .has_priv(has_priv),
  .sem_get(sem_get), .sem_free(sem_free)
);

// File: tb/privilege_relay_test.sv
`timescale 1ns/1ps
module privilege_relay_test;

  localparam int T = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pass0 = 1'b0, pass1 = 1'b0;
  logic hp0, hp1;
  logic [2:0] get0, get1, free0, free1;
  logic [2:0] gnt0, gnt1, lock, own0;

  int checks = 0;
  int errors = 0;
  bit running = 1'b0;

  typedef struct packed { logic side; logic [2:0] mask; } ev_t;
  ev_t exp_q[$];

  always #10 clk = ~clk;

  privilege_relay #(.START_PRIV(1'b1), .TMO_CYCLES(T)) uut (
    .clk(clk), .rst_n(rst_n), .pass_req(pass0), .has_priv(hp0),
    .sem_get(get0), .sem_free(free0), .sem_grant(gnt0));

  privilege_relay #(.START_PRIV(1'b0), .TMO_CYCLES(T)) peer (
    .clk(clk), .rst_n(rst_n), .pass_req(pass1), .has_priv(hp1),
    .sem_get(get1), .sem_free(free1), .sem_grant(gnt1));

  always @(posedge clk) begin
    if (!rst_n) begin
      lock <= 3'b000; own0 <= 3'b000; gnt0 <= 3'b000; gnt1 <= 3'b000;
    end else begin
      gnt0 <= get0 & ~lock;
      gnt1 <= get1 & ~lock & ~get0;
      lock <= (lock & ~free0 & ~free1) | (get0 & ~lock) | (get1 & ~lock & ~get0);
      own0 <= (own0 & ~free0) | (get0 & ~lock);
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic logic [2:0] rot_r(input logic [2:0] f);
    return {f[0], f[2:1]};
  endfunction

  // Monitor: pops the scoreboard on each free and checks the follow-up get
  logic [2:0] pend0 = 3'b000, pend1 = 3'b000;
  logic       php0 = 1'b0, php1 = 1'b0;
  always @(negedge clk) begin
    if (rst_n && running) begin
      chk(!(hp0 && hp1), "R3", "both sides privileged", int'(hp0) + int'(hp1), 1);
      if (pend0 != 3'b000) chk(get0 == pend0, "R6", "uut get after free", get0, pend0);
      if (pend1 != 3'b000) chk(get1 == pend1, "R6", "peer get after free", get1, pend1);
      pend0 = 3'b000;
      pend1 = 3'b000;
      if (free0 != 3'b000 || free1 != 3'b000) begin
        ev_t got;
        got.side = (free1 != 3'b000);
        got.mask = got.side ? free1 : free0;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5", "unexpected free", got.mask, 0);
        end else begin
          ev_t e;
          e = exp_q.pop_front();
          chk(got == e, "R8", "free order side/mask", got, e);
        end
        if (got.side) begin
          chk(!hp1 && php1, "R4", "peer priv drop at free", hp1, 0);
          pend1 = rot_r(free1);
        end else begin
          chk(!hp0 && php0, "R4", "uut priv drop at free", hp0, 0);
          pend0 = rot_r(free0);
        end
      end
    end
    php0 = hp0;
    php1 = hp1;
  end

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_up();
  end

  task automatic handover(input int h);
    bit side = h[0];
    ev_t e;
    int waited = 0;
    while (!(side ? hp1 : hp0) && waited < 400) begin
      @(negedge clk);
      waited++;
    end
    chk(waited < 400, "R7", "privilege arrival", waited, 0);
    e.side = side;
    e.mask = 3'b001 << ((2 * h) % 3);
    exp_q.push_back(e);
    if (side) pass1 = 1'b1; else pass0 = 1'b1;
    @(negedge clk);
    pass0 = 1'b0;
    pass1 = 1'b0;
    repeat (7) @(negedge clk);
  endtask

  initial begin
    int kg, kh, kq;
    logic [2:0] qget;
    int polls;
    repeat (3) @(negedge clk);
    // R1 / R3: reset state
    chk(hp0 == 1'b0 && hp1 == 1'b0, "R3", "priv in reset", hp0 | hp1, 0);
    chk(free0 == 3'b000 && free1 == 3'b000, "R3", "free in reset", free0 | free1, 0);
    rst_n = 1'b1;
    running = 1'b1;
    chk(get0 == 3'b011, "R1", "start side joint get", get0, 3);
    chk(get1 == 3'b000, "R2", "peer quiet at start", get1, 0);
    kg = -1; kh = -1; kq = -1; qget = 3'b000;
    for (int k = 1; k <= T + 8; k++) begin
      @(negedge clk);
      if (kg < 0 && gnt0 == 3'b011) kg = k;
      if (kh < 0 && hp0) kh = k;
      if (kq < 0 && get1 != 3'b000) begin kq = k; qget = get1; end
    end
    chk(kg >= 0 && kh - kg == T + 1, "R2", "start side priv delay", kh - kg, T + 1);
    chk(kq == T, "R2", "peer first get cycle", kq, T);
    chk(qget == 3'b100, "R1", "peer first get is C", qget, 4);
    // R7: peer polls A while uut holds
    polls = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (get1 == 3'b001) polls++;
    end
    chk(polls >= 8, "R7", "peer poll count for A", polls, 10);
    chk(hp1 == 1'b0 && hp0 == 1'b1, "R7", "priv while polling", hp1, 0);
    // R5: pass on the unprivileged side has no effect
    pass1 = 1'b1;
    repeat (2) @(negedge clk);
    pass1 = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(free1 == 3'b000 && hp1 == 1'b0, "R5", "ignored pass", free1, 0);
    end
    // R4 / R6 / R8: two full rounds
    for (int h = 0; h < 12; h++) begin
      handover(h);
      if (h == 5) begin
        int w = 0;
        while (!hp0 && w < 400) begin @(negedge clk); w++; end
        chk(own0 == 3'b011, "R8", "ownership after round", own0, 3);
      end
    end
    begin
      int w = 0;
      while (!hp0 && w < 400) begin @(negedge clk); w++; end
    end
    chk(own0 == 3'b011, "R8", "ownership after two rounds", own0, 3);
    chk(exp_q.size() == 0, "R4", "frees outstanding", exp_q.size(), 0);
    repeat (3) @(negedge clk);
    finish_up();
  end

endmodule